// File: doc/BRIEF.md
# Double-Buffered Serial DAC Word Register

This block takes a 12-bit converter code from a serial host and presents it as a parallel word to a converter core. The host pulls an active-low frame input low and then shifts the word in, most significant bit first. Each bit is taken on a falling edge of the serial clock. Once all twelve bits of a frame have arrived, the word goes into an input holding register. The parallel output that drives the core comes from a second register. That second register changes only on the falling edge of a separate active-low load strobe, which copies the holding register into it.

Because the two registers are separate, shifting a new word never disturbs the output. The host decides when the output moves, whether during a transfer, between transfers, or several times on the same word. All four host pins are asynchronous to the system clock. Each passes through a two-stage synchronizer, and edges are detected in the system clock domain. The system clock must run at least four times faster than the serial clock.

Top module: `dacw_top`

## Requirements
- R1: After a synchronous active-high reset, the output code is 0 and the holding register is 0, so a load strobe before any frame gives 0.
- R2: A frame starts on the falling edge of the frame input. While the frame input is low, each falling serial-clock edge shifts in one data bit, the first bit being bit 11 (MSB). The twelfth bit completes the word in the holding register.
- R3: Serial-clock falling edges after the twelfth bit of a frame are ignored until the next frame starts.
- R4: If the frame input rises before twelve bits have arrived, the holding register keeps its previous complete word.
- R5: The output code changes only on a falling edge of the load strobe, and then takes the holding register's value. A completed frame or a rising strobe edge alone leaves it unchanged.
- R6: A load strobe that falls in the middle of a frame transfers the last complete word, not the partially shifted bits.
- R7: Serial-clock edges while the frame input is high capture nothing.
- R8: The output takes its new value at the third rising system-clock edge after the load strobe pin falls, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Frame input, active low, asynchronous |
| sck | input | 1 | Serial clock from host, bits captured on falling edges |
| sdi | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Load strobe, falling edge updates output |
| dac_code | output | 12 | Parallel code to converter core |

## Verification
A wrong bit count or a wrong shift order stays inside the holding register, because that register can only be seen through the output. It becomes visible at the next load strobe, three system clocks after the strobe pin falls. For this reason every scenario ends with a strobe followed by a compare. An output register that moves without a strobe shows up at once. The bench samples the output after each frame and before the next strobe to catch this.

// File: rtl/dacw_pkg.sv
package dacw_pkg;
  localparam int NPINS    = 4;
  localparam int IDX_DATA = 0;
  localparam int IDX_SCK  = 1;
  localparam int IDX_FRM  = 2;
  localparam int IDX_LOAD = 3;
  // idle levels: strobe, frame and serial clock rest high, data low
  localparam logic [NPINS-1:0] PIN_IDLE = 4'b1110;
endpackage

// File: rtl/dacw_sync.sv
module dacw_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= RST_VAL;
        else     stage_q[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= RST_VAL;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/dacw_shift.sv
module dacw_shift #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frm_lvl,
  input  logic         frm_fall,
  input  logic         sck_fall,
  input  logic         din,
  output logic [W-1:0] word_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic          take;

  assign take = act_q && !frm_lvl && sck_fall && (cnt_q < FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      word_o <= '0;
    end else if (frm_fall) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (frm_lvl) begin
      act_q <= 1'b0;
    end else if (take) begin
      sh_q  <= {sh_q[W-2:0], din};
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) word_o <= {sh_q[W-2:0], din};
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL);  // R3
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == FULL && !frm_fall) |=> (cnt_q == FULL));  // R3
  AST_WORD_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    !(sck_fall && cnt_q == LAST) |=> $stable(word_o));  // R4
endmodule

// File: rtl/dacw_out.sv
module dacw_out #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_fall,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] code_o
);
  always_ff @(posedge clk) begin
    if (rst)            code_o <= '0;
    else if (load_fall) code_o <= word_i;
  end

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
    load_fall |=> (code_o == $past(word_i)));  // R5
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    !load_fall |=> $stable(code_o));  // R5
endmodule

// File: rtl/dacw_top.sv
module dacw_top #(
  parameter int WORD_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              load_n,
  output logic [WORD_W-1:0] dac_code
);
  import dacw_pkg::*;

  logic [NPINS-1:0]  pins_raw, pins_s;
  logic              frm_prev, sck_prev, load_prev;
  logic              frm_fall, sck_fall, load_fall;
  logic [WORD_W-1:0] held_word;

  always_comb begin
    pins_raw           = '0;
    pins_raw[IDX_DATA] = sdi;
    pins_raw[IDX_SCK]  = sck;
    pins_raw[IDX_FRM]  = frame_n;
    pins_raw[IDX_LOAD] = load_n;
  end

  dacw_sync #(.W(NPINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pins_raw),
    .dout(pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_prev  <= 1'b1;
      sck_prev  <= 1'b1;
      load_prev <= 1'b1;
    end else begin
      frm_prev  <= pins_s[IDX_FRM];
      sck_prev  <= pins_s[IDX_SCK];
      load_prev <= pins_s[IDX_LOAD];
    end
  end

  assign frm_fall  = frm_prev  && !pins_s[IDX_FRM];
  assign sck_fall  = sck_prev  && !pins_s[IDX_SCK];
  assign load_fall = load_prev && !pins_s[IDX_LOAD];

  dacw_shift #(.W(WORD_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .frm_lvl (pins_s[IDX_FRM]),
    .frm_fall(frm_fall),
    .sck_fall(sck_fall),
    .din     (pins_s[IDX_DATA]),
    .word_o  (held_word)
  );

  dacw_out #(.W(WORD_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load_fall(load_fall),
    .word_i   (held_word),
    .code_o   (dac_code)
  );

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
    load_fall |=> !load_fall);  // R8
endmodule

// File: tb/sim_dacw_top.sv
module sim_dacw_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_n = 1'b1;
  logic        sck = 1'b1;
  logic        sdi = 1'b0;
  logic        load_n = 1'b1;
  logic [11:0] dac_code;

  int checks = 0;
  int errors = 0;
  logic [11:0] exp_word = '0;
  logic [11:0] exp_code = '0;

  always #4 clk = ~clk;

  dacw_top u0 (.clk(clk), .rst(rst), .frame_n(frame_n), .sck(sck),
               .sdi(sdi), .load_n(load_n), .dac_code(dac_code));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %03h expected %03h", req, got, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    sdi = b; cyc(2);
    sck = 1'b0; cyc(4);
    sck = 1'b1; cyc(2);
  endtask

  task automatic frame(input logic [11:0] v, input int nbits, input int extra);
    frame_n = 1'b0; cyc(4);
    for (int i = 0; i < nbits; i++) bit_out(v[11-i]);
    for (int i = 0; i < extra; i++) bit_out(i[0]);
    cyc(4); frame_n = 1'b1; cyc(4);
  endtask

  task automatic strobe();
    load_n = 1'b0; cyc(4);
    load_n = 1'b1; cyc(4);
    exp_code = exp_word;
  endtask

  task automatic t_reset();
    chk("R1 reset output", dac_code, 12'h000);
    strobe();
    chk("R1 holding reg after reset", dac_code, 12'h000);
  endtask

  task automatic t_basic(input logic [11:0] v);
    frame(v, 12, 0);
    exp_word = v;
    chk("R5 no change before strobe", dac_code, exp_code);
    strobe();
    chk("R2 word after strobe", dac_code, v);
  endtask

  task automatic t_extra_clocks();
    frame(12'h3C5, 12, 3);
    exp_word = 12'h3C5;
    strobe();
    chk("R3 extra clocks ignored", dac_code, 12'h3C5);
  endtask

  task automatic t_short();
    frame(12'hFFF, 7, 0);
    strobe();
    chk("R4 short frame keeps word", dac_code, exp_word);
  endtask

  task automatic t_mid_frame();
    frame_n = 1'b0; cyc(4);
    for (int i = 0; i < 5; i++) bit_out(1'b1);
    strobe();
    chk("R6 mid-frame strobe old word", dac_code, exp_word);
    for (int i = 0; i < 7; i++) bit_out(1'b0);
    cyc(4); frame_n = 1'b1; cyc(4);
    exp_word = 12'hF80;
    chk("R5 frame end no output change", dac_code, exp_code);
    strobe();
    chk("R6 completed frame after strobe", dac_code, 12'hF80);
  endtask

  task automatic t_idle_clocks();
    for (int i = 0; i < 12; i++) bit_out(1'b1);
    strobe();
    chk("R7 clocks with frame high ignored", dac_code, exp_word);
  endtask

  task automatic t_latency();
    logic [11:0] old;
    frame(12'h6B9, 12, 0);
    old = dac_code;
    load_n = 1'b0;
    cyc(2);
    chk("R8 not yet updated after two edges", dac_code, old);
    cyc(1);
    chk("R8 updated at third edge", dac_code, 12'h6B9);
    cyc(2);
    load_n = 1'b1; cyc(6);
    chk("R5 rising strobe no change", dac_code, 12'h6B9);
    exp_word = 12'h6B9; exp_code = exp_word;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3); rst = 1'b0; cyc(3);
    t_reset();
    t_basic(12'hA5C);
    t_basic(12'hFFF);
    t_basic(12'h000);
    t_basic(12'h801);
    t_extra_clocks();
    t_short();
    t_mid_frame();
    t_idle_clocks();
    t_latency();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule